// File: doc/BRIEF.md
# I2C Register-Pointer Slave

A synchronous I2C slave front end. It gives a master access to a small bank of 16-bit registers through a pointer byte. SCL and SDA are oversampled on the system clock. From the sampled lines the block finds start, repeated start and stop conditions, and it matches a 7-bit device address. Words travel upper byte first, as a pair of bytes. The slave drives SDA open-drain only: `sda_drive_o` high means "pull the line low".

The first byte of a write sets the pointer. The bytes after it fill the selected register, upper byte then lower byte, and the pattern repeats for further pairs. A read that starts right after the address returns the register selected by the pointer written last. Each master ACK moves on to the next byte, so the slave sends lower after upper and then the pair again. The pointer is kept across stops and repeated starts. Register 0 is read-only and shows the `conv_value_i` input. Registers 1 to 3 can be read and written.

A first byte of the form 00001xxx is the high-speed master code. The slave NACKs it and raises `hs_mode_o`. The flag stays set through repeated starts and clears only on a stop.

Top module: `i2c_regptr_slave`

## Requirements
- R1: After a start, a first byte whose upper 7 bits equal DEV_ADDR is ACKed: SDA is pulled low during the 9th SCL pulse. Bit 0 of that byte selects read (1) or write (0).
- R2: A first byte with any other address gets a NACK. The slave then drives SDA for nothing until the next start or stop.
- R3: In a write, the byte after the address is ACKed and becomes the pointer. Pointer bits [1:0] select the register. The pointer keeps its value across stops and repeated starts.
- R4: The first data byte of a write goes to bits [15:8] and the second to bits [7:0], each ACKed. A stop after one data byte changes only bits [15:8].
- R5: Further byte pairs in the same write go again to the same register, upper byte first. The last pair wins.
- R6: A read sends bits [15:8] first. Each master ACK makes the slave send the next byte: bits [7:0] after an upper byte, bits [15:8] after a lower byte, with no limit. A master NACK makes the slave release SDA.
- R7: Register 0 always reads the value on conv_value_i. Writes to it are ACKed but have no effect. Registers 1 to 3 reset to 0.
- R8: A first byte matching 00001xxx is NACKed and sets hs_mode_o. hs_mode_o stays set through repeated starts, and the device address is then accepted as in R1.
- R9: A stop clears hs_mode_o. Reset also clears it.
- R10: sda_drive_o changes only after a detected SCL falling edge, and never while the sampled SCL stays high. The exception is a start or stop, which releases SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received (wired level) |
| conv_value_i | input | 16 | Value presented as read-only register 0 |
| sda_drive_o | output | 1 | When high, pull SDA low (open-drain enable) |
| hs_mode_o | output | 1 | High-speed mode flag, set by master code, cleared by stop |

## Verification
A wrong pointer or a wrong byte-side state shows up in the very next read: the returned byte comes from the wrong register or the wrong half. This is visible at most 18 SCL pulses after the faulty byte. A wrong state in the byte engine shows up within one byte as an ACK in the wrong slot or a missing ACK, or as SDA held low after a NACK. A wrong mode flag is visible on hs_mode_o a few system clocks after the master code or the stop.

// File: rtl/i2c_regptr_pkg.sv
package i2c_regptr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_WAIT
  } state_e;

  typedef enum logic [1:0] {
    BK_ADDR,
    BK_PTR,
    BK_HI,
    BK_LO
  } byte_kind_e;

  localparam logic [4:0] HS_CODE_PREFIX = 5'b00001;
endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s_o,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        scl_pipe[g] <= 1'b1;
        sda_pipe[g] <= 1'b1;
      end else if (g == 0) begin
        scl_pipe[g] <= scl_i;
        sda_pipe[g] <= sda_i;
      end else begin
        scl_pipe[g] <= scl_pipe[(g == 0) ? 0 : g-1];
        sda_pipe[g] <= sda_pipe[(g == 0) ? 0 : g-1];
      end
    end
  end

  assign scl_s_o = scl_pipe[SYNC_STAGES-1];
  assign sda_s_o = sda_pipe[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_o;
      sda_q <= sda_s_o;
    end
  end

  assign scl_rise_o = scl_s_o & ~scl_q;
  assign scl_fall_o = ~scl_s_o & scl_q;
  assign start_o    = scl_s_o & scl_q & sda_q & ~sda_s_o;
  assign stop_o     = scl_s_o & scl_q & ~sda_q & sda_s_o;
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 16,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int BYTE_W  = DATA_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_hi_i,
  input  logic              wr_lo_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [BYTE_W-1:0] wr_byte_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [DATA_W-1:0] ro_value_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] regs [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    if (g == 0) begin : g_ro
      assign regs[g] = ro_value_i;
    end else begin : g_rw
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          regs[g] <= '0;
        end else if (wr_idx_i == IDX_W'(g)) begin
          if (wr_hi_i) regs[g][DATA_W-1:BYTE_W] <= wr_byte_i;
          if (wr_lo_i) regs[g][BYTE_W-1:0]      <= wr_byte_i;
        end
      end
    end
  end

  assign rd_data_o = regs[rd_idx_i];
endmodule

// File: rtl/i2c_regptr_slave.sv
module i2c_regptr_slave
  import i2c_regptr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h52,
  parameter int         NUM_REGS    = 4,
  parameter int         SYNC_STAGES = 2,
  localparam int        DATA_W      = 16,
  localparam int        IDX_W       = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [DATA_W-1:0] conv_value_i,
  output logic              sda_drive_o,
  output logic              hs_mode_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  state_e     state_q;
  byte_kind_e kind_q;
  logic [3:0]       bit_cnt_q;
  logic [7:0]       rx_sr_q, tx_sr_q;
  logic [IDX_W-1:0] ptr_q;
  logic rw_q, tx_lo_q, mack_q, drive_q, hs_q;
  logic [DATA_W-1:0] rd_data;
  logic byte_done, wr_hi, wr_lo;

  i2c_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s_o(scl_s), .sda_s_o(sda_s), .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall), .start_o(start_det), .stop_o(stop_det)
  );

  // a data byte is committed at the falling edge that opens its ACK slot
  assign byte_done = !start_det && !stop_det && state_q == ST_RX &&
                     scl_fall && bit_cnt_q == 4'd8;
  assign wr_hi = byte_done && kind_q == BK_HI;
  assign wr_lo = byte_done && kind_q == BK_LO;

  i2c_reg_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_hi_i(wr_hi), .wr_lo_i(wr_lo),
    .wr_idx_i(ptr_q), .wr_byte_i(rx_sr_q), .rd_idx_i(ptr_q),
    .ro_value_i(conv_value_i), .rd_data_o(rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      kind_q    <= BK_ADDR;
      bit_cnt_q <= '0;
      rx_sr_q   <= '0;
      tx_sr_q   <= '0;
      ptr_q     <= '0;
      rw_q      <= 1'b0;
      tx_lo_q   <= 1'b0;
      mack_q    <= 1'b0;
      drive_q   <= 1'b0;
      hs_q      <= 1'b0;
    end else if (stop_det) begin
      state_q <= ST_IDLE;
      drive_q <= 1'b0;
      hs_q    <= 1'b0;
    end else if (start_det) begin
      state_q   <= ST_RX;
      kind_q    <= BK_ADDR;
      bit_cnt_q <= '0;
      drive_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_RX: begin
          if (scl_rise && bit_cnt_q != 4'd8) begin
            rx_sr_q   <= {rx_sr_q[6:0], sda_s};
            bit_cnt_q <= bit_cnt_q + 4'd1;
          end else if (byte_done) begin
            state_q <= ST_RX_ACK;
            drive_q <= 1'b1;
            if (kind_q == BK_ADDR) begin
              if (rx_sr_q[7:3] == HS_CODE_PREFIX) begin
                hs_q    <= 1'b1;
                drive_q <= 1'b0;
                state_q <= ST_WAIT;
              end else if (rx_sr_q[7:1] == DEV_ADDR) begin
                rw_q <= rx_sr_q[0];
              end else begin
                drive_q <= 1'b0;
                state_q <= ST_WAIT;
              end
            end else if (kind_q == BK_PTR) begin
              ptr_q <= rx_sr_q[IDX_W-1:0];
            end
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            bit_cnt_q <= '0;
            drive_q   <= 1'b0;
            if (kind_q == BK_ADDR && rw_q) begin
              state_q <= ST_TX;
              tx_lo_q <= 1'b0;
              tx_sr_q <= rd_data[15:8];
              drive_q <= ~rd_data[15];
            end else begin
              state_q <= ST_RX;
              unique case (kind_q)
                BK_ADDR: kind_q <= BK_PTR;
                BK_PTR:  kind_q <= BK_HI;
                BK_HI:   kind_q <= BK_LO;
                default: kind_q <= BK_HI;
              endcase
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bit_cnt_q == 4'd7) begin
              drive_q <= 1'b0;
              state_q <= ST_TX_ACK;
            end else begin
              tx_sr_q   <= {tx_sr_q[6:0], 1'b0};
              drive_q   <= ~tx_sr_q[6];
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) mack_q <= ~sda_s;
          if (scl_fall) begin
            if (mack_q) begin
              tx_lo_q   <= ~tx_lo_q;
              tx_sr_q   <= tx_lo_q ? rd_data[15:8] : rd_data[7:0];
              drive_q   <= tx_lo_q ? ~rd_data[15] : ~rd_data[7];
              bit_cnt_q <= '0;
              state_q   <= ST_TX;
            end else begin
              state_q <= ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_drive_o = drive_q;
  assign hs_mode_o   = hs_q;
endmodule

// File: rtl/i2c_regptr_slave_chk.sv
module i2c_regptr_slave_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_s,
  input logic start_det,
  input logic stop_det,
  input logic in_wait,
  input logic sda_drive_o,
  input logic hs_mode_o
);
  AST_SDA_STABLE_SCL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_s && $past(scl_s) && !$past(start_det) && !$past(stop_det)) |-> $stable(sda_drive_o)); // R10

  AST_RELEASE_ON_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_det || stop_det) |=> !sda_drive_o); // R10

  AST_WAIT_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_wait |-> !sda_drive_o); // R2

  AST_HS_SET_WITH_NACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_mode_o) |-> !sda_drive_o); // R8

  AST_STOP_CLEARS_HS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !hs_mode_o); // R9
endmodule

bind i2c_regptr_slave i2c_regptr_slave_chk u_chk (
  .clk_i(clk_i),
  .rst_ni(rst_ni),
  .scl_s(scl_s),
  .start_det(start_det),
  .stop_det(stop_det),
  .in_wait(state_q == i2c_regptr_pkg::ST_WAIT),
  .sda_drive_o(sda_drive_o),
  .hs_mode_o(hs_mode_o)
);

// File: tb/tb_i2c_regptr_slave.sv
module tb_i2c_regptr_slave;
  localparam logic [6:0] DEV = 7'h52;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [15:0] conv = 16'hA5C3;
  logic sda_drive, hs_mode;
  wire  sda_bus = sda_m & ~sda_drive;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  bit drive_seen = 0;
  logic [15:0] mdl [4];

  always #5 clk = ~clk;
  always @(posedge clk) if (sda_drive) drive_seen <= 1'b1;

  i2c_regptr_slave #(.DEV_ADDR(DEV)) dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .conv_value_i(conv), .sda_drive_o(sda_drive), .hs_mode_o(hs_mode)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1; wq(); scl_m = 1; wq(); sda_m = 0; wq(); scl_m = 0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 0; wq(); scl_m = 1; wq(); sda_m = 1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl_m = 1; wq(); wq(); scl_m = 0; wq();
    end
    sda_m = 1; wq(); scl_m = 1; wq(); ack = ~sda_bus; wq(); scl_m = 0; wq();
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl_m = 1; wq(); b[i] = sda_bus; wq(); scl_m = 0;
    end
    sda_m = mack ? 1'b0 : 1'b1; wq(); scl_m = 1; wq(); wq(); scl_m = 0; wq();
    sda_m = 1;
  endtask

  task automatic wr_word(input logic [7:0] ptr, input logic [15:0] v, input bit two);
    bit a;
    bus_start();
    send_byte({DEV, 1'b0}, a); chk("R1 addr ack", a, 1);
    send_byte(ptr, a);         chk("R3 ptr ack", a, 1);
    send_byte(v[15:8], a);     chk("R4 hi ack", a, 1);
    if (two) begin send_byte(v[7:0], a); chk("R4 lo ack", a, 1); end
    bus_stop();
  endtask

  task automatic rd_word(output logic [15:0] v);
    bit a;
    bus_start();
    send_byte({DEV, 1'b1}, a); chk("R1 read addr ack", a, 1);
    recv_byte(1, v[15:8]);
    recv_byte(0, v[7:0]);
    bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [7:0]  b0, b1, b2, b3;
    bit a;
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < 4; i++) mdl[i] = 16'h0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R10 reset drive", sda_drive, 0);
    chk("R9 reset hs", hs_mode, 0);

    // reset values, register 0 mirrors input
    wr_word(8'h01, 16'h0, 0); // sets pointer 1 and upper byte to 0
    rd_word(v); chk("R7 reg1 reset", v, 16'h0);
    wr_word(8'h00, 16'h1234, 1);
    rd_word(v); chk("R7 reg0 read-only", v, conv);
    conv = 16'h3C5A;
    rd_word(v); chk("R7 reg0 follows input", v, 16'h3C5A);

    // address mismatch: NACK and no drive for the rest
    drive_seen = 0;
    bus_start();
    send_byte({7'h11, 1'b0}, a); chk("R2 nack", a, 0);
    send_byte(8'h02, a); send_byte(8'hFF, a); send_byte(8'hFF, a);
    bus_stop();
    chk("R2 never driven", drive_seen, 0);
    bus_start(); send_byte({DEV, 1'b0}, a); send_byte(8'h02, a); bus_stop();
    rd_word(v); chk("R2 reg2 untouched", v, 16'h0);

    // single-byte write keeps lower byte
    wr_word(8'h03, 16'hBEEF, 1); mdl[3] = 16'hBEEF;
    wr_word(8'h03, 16'h7700, 0); mdl[3] = 16'h77EF;
    rd_word(v); chk("R4 single byte upper only", v, mdl[3]);

    // repeated pairs in one write
    bus_start();
    send_byte({DEV, 1'b0}, a); send_byte(8'h01, a);
    send_byte(8'h11, a); send_byte(8'h22, a);
    send_byte(8'h33, a); chk("R5 second pair ack", a, 1);
    send_byte(8'h44, a);
    bus_stop(); mdl[1] = 16'h3344;
    rd_word(v); chk("R5 last pair wins", v, 16'h3344);

    // streaming read: hi, lo, hi, lo then release
    bus_start();
    send_byte({DEV, 1'b1}, a);
    recv_byte(1, b0); recv_byte(1, b1); recv_byte(1, b2); recv_byte(0, b3);
    chk("R6 first byte upper", b0, 8'h33);
    chk("R6 second byte lower", b1, 8'h44);
    chk("R6 third byte upper again", b2, 8'h33);
    chk("R6 fourth byte lower", b3, 8'h44);
    repeat (8) @(negedge clk);
    chk("R6 released after nack", sda_drive, 0);
    bus_stop();

    // pointer set, repeated start, read
    bus_start();
    send_byte({DEV, 1'b0}, a); send_byte(8'h03, a);
    bus_start();
    send_byte({DEV, 1'b1}, a); chk("R3 read after rstart ack", a, 1);
    recv_byte(1, b0); recv_byte(0, b1);
    bus_stop();
    chk("R3 pointer across rstart", {b0, b1}, mdl[3]);
    rd_word(v); chk("R3 pointer across stop", v, mdl[3]);

    // high-speed master code
    bus_start();
    send_byte(8'h0D, a); chk("R8 master code nack", a, 0);
    repeat (4) @(negedge clk);
    chk("R8 hs set", hs_mode, 1);
    bus_start();
    send_byte({DEV, 1'b0}, a); chk("R8 addr ack in hs", a, 1);
    send_byte(8'h02, a); send_byte(8'h5A, a); send_byte(8'hC3, a);
    mdl[2] = 16'h5AC3;
    bus_start();
    chk("R8 hs kept over rstart", hs_mode, 1);
    send_byte({DEV, 1'b1}, a);
    recv_byte(1, b0); recv_byte(0, b1);
    chk("R8 hs read data", {b0, b1}, 16'h5AC3);
    bus_stop();
    repeat (4) @(negedge clk);
    chk("R9 stop clears hs", hs_mode, 0);

    // random register traffic
    for (int it = 0; it < 24; it++) begin
      logic [7:0]  p;
      logic [15:0] d;
      bit two;
      p   = 8'($urandom_range(0, 255));
      d   = 16'($urandom);
      two = 1'($urandom_range(0, 1));
      wr_word(p, d, two);
      if (p[1:0] != 2'd0) begin
        if (two) mdl[p[1:0]] = d;
        else mdl[p[1:0]][15:8] = d[15:8];
      end
      rd_word(v);
      chk(p[1:0] == 2'd0 ? "R7 random reg0" : "R3 random readback", v,
          p[1:0] == 2'd0 ? conv : mdl[p[1:0]]);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule